// File: doc/BRIEF.md
# Multi-format LVDS pixel serializer

This block turns one parallel pixel (8-bit red, green and blue plus horizontal sync, vertical sync and data enable) into seven serial bit slots on each of four single-ended data lanes, and produces a matching clock-lane bit stream. The serial side advances one slot for each cycle in which the bit-rate enable `bit_en` is high. That enable is asserted seven times per pixel period. A slot counter runs from 0 to 6. On the enabled cycle that ends slot 6, the counter wraps and each lane shift register is loaded with the next pixel.

A two-bit map select chooses one of three incompatible colour-to-slot layouts: an 18-bit layout on three lanes, a 24-bit layout that puts the two low colour bits on lane 3, and a 24-bit layout that puts the two high colour bits on lane 3. A mirror input reverses the slot order on every data lane. The pixel, the map select and the mirror input are sampled only at the pixel boundary, so no period mixes two layouts. Differential drivers, clock synthesis and timing generation sit outside the block.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: While `rst_n` is low and through the first full pixel period after its release, every data lane outputs 0, and the slot counter starts at slot 0.
- R2: The slot position advances only on clock edges where `bit_en` is 1. With `bit_en` at 0, all data lanes and the clock lane hold their values.
- R3: The clock lane outputs 1,1,0,0,0,1,1 for slots 0 to 6 of every period, regardless of the data.
- R4: With `map_sel`=0, only the six high colour bits r[7:2], g[7:2] and b[7:2] are used, written here as R0..R5, G0..G5 and B0..B5. Lane 0 slots 0..6 carry R0..R5 and G0. Lane 1 carries G1..G5, B0 and B1. Lane 2 carries B2..B5, hsync, vsync and de. Lane 3 stays 0.
- R5: With `map_sel`=1, lanes 0 to 2 are the same as in R4. Lane 3 slots 0..6 carry r[0], r[1], g[0], g[1], b[0], b[1] and 0.
- R6: With `map_sel`=2, lanes 0 to 2 use the R4 layout, but filled from the low bits r[5:0], g[5:0] and b[5:0]. Lane 3 slots 0..6 carry r[6], r[7], g[6], g[7], b[6], b[7] and 0.
- R7: A `map_sel` value of 3 gives the same output as 0.
- R8: With `mirror`=1, serial slot k of every data lane carries the bit that slot 6-k would carry without mirroring.
- R9: The pixel, `map_sel` and `mirror` are sampled only on the enabled edge that ends slot 6. Changes at any other time have no effect on the data lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Slot advance enable, seven pulses per pixel period |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | Colour-to-slot layout select |
| mirror | input | 1 | Reverse the slot order on all data lanes |
| lane_out | output | 4 | Serial data bit for each lane |
| clk_lane_out | output | 1 | Serial clock-lane bit |

## Verification
A slot counter that slips by one shows up at once on the clock lane, because the 1100011 pattern moves against the data. It also shows on the data lanes from the next boundary on, because the load then happens in the wrong slot. A shift register that was loaded wrongly, or that shifts without an enable, corrupts a lane bit in the very slot it affects. A layout or mirror select sampled at the wrong moment shows as a wrong bit within the following pixel period. The bench therefore compares all four lanes and the clock lane in every slot of every period, including enable gaps and input changes in the middle of a period.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int LANES     = 4;
  localparam int SLOTS     = 7;
  localparam int COLOR_W   = 8;
  localparam int BASE_BITS = 6;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  typedef enum logic [1:0] {
    MAP_NARROW  = 2'd0,
    MAP_WIDE_LO = 2'd1,
    MAP_WIDE_HI = 2'd2,
    MAP_ALIAS   = 2'd3
  } map_e;

  typedef logic [SLOTS-1:0] lane_word_t;
  typedef logic [LANES-1:0][SLOTS-1:0] lane_bundle_t;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  function automatic lane_word_t reverse_slots(lane_word_t w);
    lane_word_t res;
    for (int i = 0; i < SLOTS; i++) res[i] = w[SLOTS-1-i];
    return res;
  endfunction

  function automatic logic clk_pattern(logic [SLOT_W-1:0] slot);
    return CLK_PATTERN[slot];
  endfunction

  // Lanes 0..2: colour stream r6, g6, b6 followed by the three controls.
  function automatic logic [2:0][SLOTS-1:0] pack_base(
    logic [BASE_BITS-1:0] r6, logic [BASE_BITS-1:0] g6,
    logic [BASE_BITS-1:0] b6, logic hs, logic vs, logic de);
    logic [3*SLOTS-1:0]        stream;
    logic [2:0][SLOTS-1:0]     res;
    stream = {de, vs, hs, b6, g6, r6};
    for (int l = 0; l < 3; l++) res[l] = stream[l*SLOTS +: SLOTS];
    return res;
  endfunction

  function automatic lane_bundle_t map_pixel(map_e m, pixel_t p);
    lane_bundle_t          res;
    logic [2:0][SLOTS-1:0] base;
    case (m)
      MAP_WIDE_LO: begin
        base = pack_base(p.r[7:2], p.g[7:2], p.b[7:2], p.hs, p.vs, p.de);
        res[3] = {1'b0, p.b[1:0], p.g[1:0], p.r[1:0]};
      end
      MAP_WIDE_HI: begin
        base = pack_base(p.r[5:0], p.g[5:0], p.b[5:0], p.hs, p.vs, p.de);
        res[3] = {1'b0, p.b[7:6], p.g[7:6], p.r[7:6]};
      end
      default: begin
        base = pack_base(p.r[7:2], p.g[7:2], p.b[7:2], p.hs, p.vs, p.de);
        res[3] = '0;
      end
    endcase
    for (int l = 0; l < 3; l++) res[l] = base[l];
    return res;
  endfunction
endpackage

// File: rtl/lvds_slot_counter.sv
module lvds_slot_counter
  import lvds_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  output logic [SLOT_W-1:0] slot_q,
  output logic              wrap,
  output logic              clk_lane
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  assign wrap = bit_en && (slot_q == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slot_q <= '0;
    else if (wrap)   slot_q <= '0;
    else if (bit_en) slot_q <= slot_q + SLOT_W'(1);
  end

  assign clk_lane = clk_pattern(slot_q);
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_ser_pkg::*;
(
  input  pixel_t       pix,
  input  logic [1:0]   map_sel,
  output lane_bundle_t words
);
  always_comb words = map_pixel(map_e'(map_sel), pix);
endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter
  import lvds_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       load,
  input  logic       mirror,
  input  lane_word_t word,
  output logic       ser
);
  lane_word_t sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (load)   sh_q <= mirror ? reverse_slots(word) : word;
    else if (bit_en) sh_q <= {1'b0, sh_q[SLOTS-1:1]};
  end

  assign ser = sh_q[0];
endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic [COLOR_W-1:0] pix_r,
  input  logic [COLOR_W-1:0] pix_g,
  input  logic [COLOR_W-1:0] pix_b,
  input  logic               pix_hs,
  input  logic               pix_vs,
  input  logic               pix_de,
  input  logic [1:0]         map_sel,
  input  logic               mirror,
  output logic [LANES-1:0]   lane_out,
  output logic               clk_lane_out
);
  logic [SLOT_W-1:0] slot_q;
  logic              wrap_evt;
  logic [1:0]        map_q;
  pixel_t            pix_in;
  lane_bundle_t      words;

  assign pix_in = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hs, vs: pix_vs, de: pix_de};

  lvds_slot_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .slot_q   (slot_q),
    .wrap     (wrap_evt),
    .clk_lane (clk_lane_out)
  );

  lvds_lane_mapper u_map (
    .pix     (pix_in),
    .map_sel (map_sel),
    .words   (words)
  );

  // Layout in force for the current period, exposed to the checker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        map_q <= 2'(MAP_NARROW);
    else if (wrap_evt) map_q <= map_sel;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lvds_lane_shifter u_sh (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .load   (wrap_evt),
      .mirror (mirror),
      .word   (words[l]),
      .ser    (lane_out[l])
    );
  end
endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker
  import lvds_ser_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bit_en,
  input logic [SLOT_W-1:0] slot_q,
  input logic              wrap_evt,
  input logic [1:0]        map_q,
  input logic [LANES-1:0]  lane_out,
  input logic              clk_lane_out
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slot_q == '0 && lane_out == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(slot_q) && $stable(lane_out) && $stable(clk_lane_out)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_q != LAST) |=> slot_q == $past(slot_q) + SLOT_W'(1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_q == LAST) |=> (slot_q == '0 && $past(wrap_evt)));

  p_clk_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q < 3'd2 || slot_q > 3'd4) |-> clk_lane_out);

  p_clk_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q >= 3'd2 && slot_q <= 3'd4) |-> !clk_lane_out);

  p_idle_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_q == 2'd0 || map_q == 2'd3) |-> !lane_out[3]);
endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_en       (bit_en),
  .slot_q       (slot_q),
  .wrap_evt     (wrap_evt),
  .map_q        (map_q),
  .lane_out     (lane_out),
  .clk_lane_out (clk_lane_out)
);

// File: tb/lvds_pixel_serializer_tb.sv
module lvds_pixel_serializer_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bit_en = 0;
  logic [7:0] pix_r = 0, pix_g = 0, pix_b = 0;
  logic       pix_hs = 0, pix_vs = 0, pix_de = 0;
  logic [1:0] map_sel = 0;
  logic       mirror = 0;
  logic [3:0] lane_out;
  logic       clk_lane_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // expected content of the running period and the next one
  logic [7:0] cur_r, cur_g, cur_b, nxt_r, nxt_g, nxt_b;
  logic       cur_hs, cur_vs, cur_de, nxt_hs, nxt_vs, nxt_de;
  logic [1:0] cur_m, nxt_m;
  logic       cur_mir, nxt_mir;
  bit         cur_blank;
  string      cur_tag, nxt_tag;

  always #2 clk = ~clk;

  lvds_pixel_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
    .map_sel(map_sel), .mirror(mirror),
    .lane_out(lane_out), .clk_lane_out(clk_lane_out)
  );

  // Expected bit, from the slot tables in R4..R8.
  function automatic logic exp_bit(int lane, int slot);
    int pos, m, off, idx;
    if (cur_blank) return 1'b0;
    pos = cur_mir ? 6 - slot : slot;
    m = (cur_m == 2'd3) ? 0 : int'(cur_m);
    if (lane == 3) begin
      if (m == 0 || pos == 6) return 1'b0;
      off = (m == 1) ? 0 : 6;
      case (pos / 2)
        0: return cur_r[off + pos % 2];
        1: return cur_g[off + pos % 2];
        default: return cur_b[off + pos % 2];
      endcase
    end
    off = (m == 2) ? 0 : 2;
    idx = lane * 7 + pos;
    if (idx < 6)   return cur_r[off + idx];
    if (idx < 12)  return cur_g[off + idx - 6];
    if (idx < 18)  return cur_b[off + idx - 12];
    if (idx == 18) return cur_hs;
    if (idx == 19) return cur_vs;
    return cur_de;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_slot(input int s, input string tag);
    for (int l = 0; l < 4; l++)
      check(tag, $sformatf("lane %0d slot %0d", l, s), lane_out[l], exp_bit(l, s));
    check("R3", $sformatf("clock lane slot %0d", s), clk_lane_out, (s < 2 || s > 4));
  endtask

  task automatic drive_nxt();
    pix_r = nxt_r; pix_g = nxt_g; pix_b = nxt_b;
    pix_hs = nxt_hs; pix_vs = nxt_vs; pix_de = nxt_de;
    map_sel = nxt_m; mirror = nxt_mir;
  endtask

  task automatic load(input logic [1:0] m, input logic mir, input logic [7:0] r,
                      input logic [7:0] g, input logic [7:0] b, input logic [2:0] ctl,
                      input string tag);
    nxt_m = m; nxt_mir = mir; nxt_r = r; nxt_g = g; nxt_b = b;
    nxt_hs = ctl[0]; nxt_vs = ctl[1]; nxt_de = ctl[2]; nxt_tag = tag;
  endtask

  // One pixel period; called at a falling edge with slot 0 on the outputs.
  task automatic period(input bit gap, input bit glitch);
    for (int s = 0; s < 7; s++) begin
      check_slot(s, cur_tag);
      if (gap && s == 2) begin
        bit_en = 0;
        repeat (3) begin
          @(posedge clk); @(negedge clk);
          check_slot(s, "R2");
        end
        bit_en = 1;
      end
      if (glitch && s == 3) begin
        pix_r = 8'($urandom); pix_g = 8'($urandom); pix_b = 8'($urandom);
        {pix_hs, pix_vs, pix_de} = 3'($urandom);
        map_sel = ~nxt_m; mirror = ~nxt_mir;
      end
      if (s == 6) drive_nxt();
      @(posedge clk); @(negedge clk);
    end
    cur_r = nxt_r; cur_g = nxt_g; cur_b = nxt_b;
    cur_hs = nxt_hs; cur_vs = nxt_vs; cur_de = nxt_de;
    cur_m = nxt_m; cur_mir = nxt_mir; cur_tag = nxt_tag; cur_blank = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; bit_en = 0;
    repeat (3) @(negedge clk);
    check("R1", "lane_out in reset", lane_out[0] | lane_out[1] | lane_out[2] | lane_out[3], 1'b0);
    check("R1", "clock lane in reset", clk_lane_out, 1'b1);
    cur_blank = 1; cur_tag = "R1";
    pix_r = 8'hFF; pix_g = 8'hFF; pix_b = 8'hFF; {pix_hs, pix_vs, pix_de} = 3'b111;
    rst_n = 1; bit_en = 1;
  endtask

  task automatic t_narrow();        // R4
    load(2'd0, 0, 8'b1010_0111, 8'b0110_1101, 8'b1100_1010, 3'b101, "R4");
    period(0, 0);
    load(2'd0, 0, 8'b0101_1000, 8'b1001_0010, 8'b0011_0101, 3'b010, "R4");
    period(0, 0);
  endtask

  task automatic t_wide_lo();       // R5
    load(2'd1, 0, 8'b1110_0001, 8'b0001_1110, 8'b1011_0110, 3'b110, "R5");
    period(0, 0);
    load(2'd1, 0, 8'b0001_1110, 8'b1110_0001, 8'b0100_1001, 3'b001, "R5");
    period(0, 0);
  endtask

  task automatic t_wide_hi();       // R6
    load(2'd2, 0, 8'b0111_0010, 8'b1000_1101, 8'b1101_0100, 3'b011, "R6");
    period(0, 0);
    load(2'd2, 0, 8'b1000_1101, 8'b0111_0010, 8'b0010_1011, 3'b100, "R6");
    period(0, 0);
  endtask

  task automatic t_alias_gap();     // R7, with an enable gap (R2)
    load(2'd3, 0, 8'b1101_1011, 8'b0010_0110, 8'b1111_0000, 3'b111, "R7");
    period(0, 0);
    load(2'd1, 1, 8'b1001_0110, 8'b0110_1001, 8'b1010_0101, 3'b101, "R8");
    period(1, 0);
  endtask

  task automatic t_mirror();        // R8
    load(2'd2, 1, 8'b1100_0011, 8'b0011_1100, 8'b0101_1010, 3'b011, "R8");
    period(0, 0);
    load(2'd0, 1, 8'b1011_0001, 8'b0100_1110, 8'b1000_0111, 3'b110, "R9");
    period(0, 0);
  endtask

  task automatic t_capture();       // R9: mid-period changes are ignored
    period(0, 1);
    load(2'd2, 0, 8'b0110_0110, 8'b1001_1001, 8'b1110_1110, 3'b010, "R9");
    period(0, 1);
    load(2'd0, 0, 8'h00, 8'h00, 8'h00, 3'b000, "R4");
    period(0, 0);
    period(0, 0);
  endtask

  initial begin
    t_reset();
    load(2'd0, 0, 8'h00, 8'h00, 8'h00, 3'b000, "R4");
    period(0, 0);                   // blank first period: R1
    t_narrow();
    t_wide_lo();
    t_wide_hi();
    t_alias_gap();
    t_mirror();
    t_capture();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule